// File: doc/BRIEF.md
# Clock Fanout Output Enable and Mode Control

This block sits between the serial control slave and the output stage of a one-input, twelve-pair clock fanout. It keeps two host-writable enable registers, one bit per output pair, and turns the reference clock into a true pin and a complement pin for each pair. It also drives a feedback copy of the reference and the output-enable lines used by the tri-state pads. The clock is handled as an ordinary logic signal. Pad drive strength, supply switching and skew are handled outside this block.

A mode pin chooses how the lower six pairs (0 to 5) behave. When the pin is high, each of these pairs is differential. When it is low, both pins of each pair carry the true clock, so the pair acts as two single-ended outputs. Pairs 6 to 11 are always differential. The mode pin can be read back in the upper register. A stopped pair holds both of its pins low.

The host sets an enable bit at any time. The new value reaches the output gating only on a clock edge where the reference is low, so a pulse is never cut short. An active-low power-down input releases every output to high impedance.

Top module: `clk_fanout_ctrl`

## Requirements
- R1: After reset every pair is enabled. Index 7 reads 0xFF. Index 6 reads 0xFF with the mode pin high and 0x7F with it low.
- R2: A write to index 7 stores bit i as the enable of pair i (i = 0..7), where 1 means running. The register reads back the stored byte on the next cycle.
- R3: A write to index 6 stores bits 1, 2, 3 and 4 as the enables of pairs 8, 9, 10 and 11. In a read of index 6, bit 7 returns the mode pin level, and bits 6, 5 and 0 always read 1. Written values in bits 7, 6, 5 and 0 are ignored.
- R4: Reads of any index other than 6 and 7 return 0xFF. Writes to other indices change no enable and no read value.
- R5: A pair whose applied enable is 0 drives 0 on both its true pin and its complement pin.
- R6: A stored enable becomes the applied enable on the first clk_i rising edge at which ref_clk_i is low. While ref_clk_i stays high, the previously applied value is kept.
- R7: For an enabled pair 0..5, the true pin equals ref_clk_i. The complement pin equals the inverse of ref_clk_i when mode_sel_i is 1, and equals ref_clk_i when mode_sel_i is 0.
- R8: For an enabled pair 6..11, the true pin equals ref_clk_i and the complement pin equals its inverse, whatever the mode. fb_o always equals ref_clk_i.
- R9: While pwr_dn_ni is 0, every bit of pair_oe_o and fb_oe_o is 0. While pwr_dn_ni is 1, all of them are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | Reference clock to be fanned out |
| mode_sel_i | input | 1 | 1: pairs 0..5 differential; 0: pairs 0..5 single-ended copies |
| pwr_dn_ni | input | 1 | Power-down, active low; tri-states all outputs |
| wr_en_i | input | 1 | Register write strobe from serial slave |
| wr_idx_i | input | 8 | Register write index |
| wr_data_i | input | 8 | Register write data |
| rd_idx_i | input | 8 | Register read index |
| rd_data_o | output | 8 | Register read data (combinational) |
| pair_t_o | output | 12 | True pin of each pair |
| pair_c_o | output | 12 | Complement pin of each pair |
| pair_oe_o | output | 12 | Output enable of each pair |
| fb_o | output | 1 | Feedback copy of the reference |
| fb_oe_o | output | 1 | Output enable of the feedback pin |

## Verification
A behavioural model in the bench is compared against every output on every cycle. The stimulus mixes random register traffic to indices 5, 6, 7 and 9 with a reference that toggles at random and with random changes to the mode and power-down inputs. The random toggling separates a design that applies enables at once from one that waits for a low reference phase. Flipping the mode shows whether the lower and upper pairs follow their own complement rules. The random traffic to indices 5 and 9 exposes any decode leak. A directed sequence writes a stop while the reference is held high, checks that the pair keeps running, and then checks that it stops after a low phase. The reset read values are checked with both mode levels.

// File: rtl/ckf_pkg.sv
package ckf_pkg;
  localparam int NUM_PAIRS = 12;
  localparam int NUM_MIXED = 6;
  localparam int NUM_HI    = 4;
  localparam int NUM_LO    = NUM_PAIRS - NUM_HI;
  localparam int IDX_W     = 8;
  localparam int DATA_W    = 8;
  localparam int HI_LSB    = 1;
  localparam logic [IDX_W-1:0]  IDX_HI     = 8'd6;
  localparam logic [IDX_W-1:0]  IDX_LO     = 8'd7;
  localparam logic [DATA_W-1:0] RD_DEFAULT = 8'hFF;
  typedef logic [NUM_PAIRS-1:0] pair_vec_t;
endpackage

// File: rtl/ckf_regs.sv
module ckf_regs
  import ckf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_sel_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output pair_vec_t         en_o
);
  pair_vec_t en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '1;
    end else if (wr_en_i) begin
      if (wr_idx_i == IDX_LO) en_q[NUM_LO-1:0] <= wr_data_i[NUM_LO-1:0];
      if (wr_idx_i == IDX_HI) en_q[NUM_PAIRS-1 -: NUM_HI] <= wr_data_i[HI_LSB +: NUM_HI];
    end
  end

  always_comb begin
    rd_data_o = RD_DEFAULT;
    if (rd_idx_i == IDX_LO) begin
      rd_data_o = en_q[NUM_LO-1:0];
    end else if (rd_idx_i == IDX_HI) begin
      rd_data_o[DATA_W-1]          = mode_sel_i;
      rd_data_o[HI_LSB +: NUM_HI]  = en_q[NUM_PAIRS-1 -: NUM_HI];
    end
  end

  assign en_o = en_q;

  AST_WR_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == IDX_LO) |=> en_q[NUM_LO-1:0] == $past(wr_data_i[NUM_LO-1:0])); // R2
  AST_WR_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == IDX_HI) |=> en_q[NUM_PAIRS-1 -: NUM_HI] == $past(wr_data_i[HI_LSB +: NUM_HI])); // R3
  AST_NO_STRAY_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || (wr_idx_i != IDX_LO && wr_idx_i != IDX_HI)) |=> $stable(en_q)); // R4
endmodule

// File: rtl/ckf_sync.sv
module ckf_sync
  import ckf_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ref_clk_i,
  input  pair_vec_t en_i,
  output pair_vec_t en_app_o
);
  pair_vec_t app_q;

  // only update while reference is low: gating edge can never truncate a high pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         app_q <= '1;
    else if (!ref_clk_i) app_q <= en_i;
  end

  assign en_app_o = app_q;

  AST_LOW_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ref_clk_i) |-> $stable(app_q)); // R6
endmodule

// File: rtl/ckf_pair.sv
module ckf_pair #(
  parameter bit IS_MIXED = 1'b0
) (
  input  logic ref_clk_i,
  input  logic en_i,
  input  logic mode_sel_i,
  output logic t_o,
  output logic c_o
);
  logic c_raw;

  generate
    if (IS_MIXED) begin : g_mixed
      assign c_raw = mode_sel_i ? ~ref_clk_i : ref_clk_i;
    end else begin : g_diff
      assign c_raw = ~ref_clk_i;
    end
  endgenerate

  assign t_o = en_i & ref_clk_i;
  assign c_o = en_i & c_raw;
endmodule

// File: rtl/clk_fanout_ctrl.sv
module clk_fanout_ctrl
  import ckf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic              mode_sel_i,
  input  logic              pwr_dn_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NUM_PAIRS-1:0] pair_t_o,
  output logic [NUM_PAIRS-1:0] pair_c_o,
  output logic [NUM_PAIRS-1:0] pair_oe_o,
  output logic              fb_o,
  output logic              fb_oe_o
);
  pair_vec_t en_s;
  pair_vec_t en_app;

  ckf_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_sel_i (mode_sel_i),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_data_i  (wr_data_i),
    .rd_idx_i   (rd_idx_i),
    .rd_data_o  (rd_data_o),
    .en_o       (en_s)
  );

  ckf_sync u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_clk_i (ref_clk_i),
    .en_i      (en_s),
    .en_app_o  (en_app)
  );

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    ckf_pair #(.IS_MIXED(g < NUM_MIXED)) u_pair (
      .ref_clk_i  (ref_clk_i),
      .en_i       (en_app[g]),
      .mode_sel_i (mode_sel_i),
      .t_o        (pair_t_o[g]),
      .c_o        (pair_c_o[g])
    );
  end

  assign pair_oe_o = {NUM_PAIRS{pwr_dn_ni}};
  assign fb_o      = ref_clk_i;
  assign fb_oe_o   = pwr_dn_ni;

  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pair_t_o | pair_c_o) & ~en_app) == '0); // R5
  AST_PD_TRI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_dn_ni |-> (pair_oe_o == '0 && !fb_oe_o)); // R9
  AST_UPPER_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pair_t_o[NUM_PAIRS-1:NUM_MIXED] & pair_c_o[NUM_PAIRS-1:NUM_MIXED]) == '0)); // R8
endmodule

// File: tb/clk_fanout_ctrl_tb.sv
module clk_fanout_ctrl_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_clk = 1'b0, mode_sel = 1'b1, pwr_dn_n = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_idx = '0, wr_data = '0, rd_idx = 8'd7;
  logic [7:0] rd_data;
  logic [11:0] pt, pc, poe;
  logic fb, fb_oe;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clk_fanout_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_clk_i(ref_clk), .mode_sel_i(mode_sel),
    .pwr_dn_ni(pwr_dn_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .pair_t_o(pt), .pair_c_o(pc),
    .pair_oe_o(poe), .fb_o(fb), .fb_oe_o(fb_oe)
  );

  // reference model
  bit m_en [12];
  bit m_app [12];
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_en[i]) begin m_en[i] <= 1'b1; m_app[i] <= 1'b1; end
    end else begin
      if (wr_en && wr_idx == 8'd7) for (int i = 0; i < 8; i++) m_en[i] <= wr_data[i];
      if (wr_en && wr_idx == 8'd6) for (int i = 8; i < 12; i++) m_en[i] <= wr_data[i-7];
      if (!ref_clk) foreach (m_app[i]) m_app[i] <= m_en[i];
    end
  end

  function automatic logic [7:0] exp_rd(logic [7:0] idx);
    logic [7:0] v;
    v = 8'hFF;
    if (idx == 8'd7) for (int i = 0; i < 8; i++) v[i] = m_en[i];
    else if (idx == 8'd6) begin
      v[7] = mode_sel;
      for (int i = 8; i < 12; i++) v[i-7] = m_en[i];
    end
    return v;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      string rtag;
      rtag = (rd_idx == 8'd6) ? "R3" : (rd_idx == 8'd7) ? "R2" : "R4";
      chk(rd_data == exp_rd(rd_idx), rtag, "rd_data", rd_data, exp_rd(rd_idx));
      for (int i = 0; i < 12; i++) begin
        logic et, ec;
        string tg;
        et = m_app[i] & ref_clk;
        ec = !m_app[i] ? 1'b0 : (i < 6 && !mode_sel) ? ref_clk : ~ref_clk;
        tg = !m_app[i] ? "R5" : (i < 6) ? "R7" : "R8";
        chk(pt[i] == et && pc[i] == ec, tg, $sformatf("pair%0d t/c", i), {pt[i], pc[i]}, {et, ec});
      end
      chk(fb == ref_clk, "R8", "fb", fb, ref_clk);
      chk(poe == {12{pwr_dn_n}} && fb_oe == pwr_dn_n, "R9", "oe", {fb_oe, poe}, {13{pwr_dn_n}});
    end
  end

  task automatic step(bit we, logic [7:0] wi, logic [7:0] wd, bit rf, bit md, bit pd, logic [7:0] ri);
    @(posedge clk); #2;
    wr_en = we; wr_idx = wi; wr_data = wd; ref_clk = rf; mode_sel = md; pwr_dn_n = pd; rd_idx = ri;
  endtask

  initial begin
    #(20 * 200000);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] idxs [4];
    idxs = '{8'd5, 8'd6, 8'd7, 8'd9};
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    // R1 reset values
    step(0, 0, 0, 1, 1, 1, 8'd6);
    @(negedge clk); #1;
    chk(rd_data == 8'hFF, "R1", "idx6 mode=1", rd_data, 8'hFF);
    chk(pt == 12'hFFF, "R1", "all running", pt, 12'hFFF);
    step(0, 0, 0, 1, 0, 1, 8'd6);
    @(negedge clk); #1;
    chk(rd_data == 8'h7F, "R1", "idx6 mode=0", rd_data, 8'h7F);
    step(0, 0, 0, 1, 0, 1, 8'd7);
    @(negedge clk); #1;
    chk(rd_data == 8'hFF, "R1", "idx7", rd_data, 8'hFF);
    // R6 directed: stop pair0 while reference high
    step(1, 8'd7, 8'hFE, 1, 1, 1, 8'd7);
    step(0, 0, 0, 1, 1, 1, 8'd7);
    @(negedge clk); #1;
    chk(pt[0] == 1'b1, "R6", "held while ref high", pt[0], 1);
    chk(rd_data == 8'hFE, "R2", "readback", rd_data, 8'hFE);
    step(0, 0, 0, 1, 1, 1, 8'd7);
    @(negedge clk); #1;
    chk(pt[0] == 1'b1, "R6", "still held", pt[0], 1);
    step(0, 0, 0, 0, 1, 1, 8'd7);
    step(0, 0, 0, 1, 1, 1, 8'd7);
    @(negedge clk); #1;
    chk(pt[0] == 1'b0 && pc[0] == 1'b0, "R6", "stopped after low", {pt[0], pc[0]}, 0);
    // R3 reserved and read-only bits ignore writes
    step(0, 0, 0, 0, 1, 1, 8'd6);
    step(1, 8'd6, 8'h00, 0, 1, 1, 8'd6);
    step(0, 0, 0, 0, 0, 1, 8'd6);
    @(negedge clk); #1;
    chk(rd_data == 8'h61, "R3", "idx6 after zero write", rd_data, 8'h61);
    // R4 stray write
    step(1, 8'd9, 8'h00, 0, 0, 1, 8'd7);
    step(0, 0, 0, 0, 0, 1, 8'd7);
    @(negedge clk); #1;
    chk(rd_data == 8'hFE, "R4", "idx7 untouched", rd_data, 8'hFE);
    // random traffic
    for (int k = 0; k < 2000; k++) begin
      step(($urandom % 3) == 0, idxs[$urandom % 4], 8'($urandom), 1'($urandom),
           ($urandom % 16) != 0 ? mode_sel : ~mode_sel, ($urandom % 10) != 0, idxs[$urandom % 4]);
    end
    @(negedge clk); #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule